// File: doc/BRIEF.md
# Single-Port RAM Stream Bridge

This block connects a pair of valid/ready streams to the pins of a single-port RAM that has a fixed read latency. A producer sends request beats on the request stream. Each beat carries an address, write data, a write strobe and a read strobe. Every beat that asks for a read later produces exactly one beat on the response stream, which carries the read data. Beats that only write produce no response.

The RAM pins carry no flow control, so returning read data cannot be held off. The bridge stores returning words in a small response buffer. It admits a read only when that buffer is sure to have room for every read still in flight, which makes overflow impossible. A request is handed to the RAM in the cycle it is accepted: address, write data and strobes drive the pins directly.

Back-pressure rules:
- A request beat transfers on a cycle with `req_valid && req_ready`.
- A response beat transfers on a cycle with `resp_valid && resp_ready`.
- `req_ready` depends on the `req_re` field of the offered beat. It may drop only for beats that read.
- Once `resp_valid` is raised, it and `resp_rdata` hold until the beat is taken.

Top module: `ram_chan_bridge`

## Requirements
- R1: A request beat with `req_re`=0 is always accepted (`req_ready`=1), whatever the state of the response buffer.
- R2: In an accepted cycle, `ram_addr` and `ram_wdata` equal the beat's address and write data, `ram_we` equals `req_we` and `ram_re` equals `req_re`. In every other cycle `ram_we` and `ram_re` are 0.
- R3: `ram_rdata` is captured exactly LATENCY cycles after the cycle in which `ram_re` was high. With an empty buffer and a ready consumer, `resp_valid` rises LATENCY+1 cycles after the accepting cycle.
- R4: Only beats with `req_re`=1 produce a response. A write-only beat produces none, and the number of responses equals the number of accepted reads.
- R5: A read is accepted only if the words stored, plus the reads in flight, plus this one, minus a response leaving in the same cycle, do not exceed RESP_DEPTH. With the consumer stalled from an idle state, exactly RESP_DEPTH reads are accepted.
- R6: Responses leave in the same order as their reads were accepted.
- R7: A beat with both `req_we`=1 and `req_re`=1 performs the write, and its response carries the word stored before that write.
- R8: While `resp_valid`=1 and `resp_ready`=0, `resp_valid` stays 1 and `resp_rdata` stays unchanged on the next cycle.
- R9: During and right after reset (active-low `rst_n`), `resp_valid`=0 and `req_ready`=1 even for a read beat. `ram_we` and `ram_re` are 0 while no beat is offered.
- R10: With RESP_DEPTH = LATENCY+1 and a consumer that is always ready, back-to-back reads are accepted every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request beat offered |
| req_ready | output | 1 | Request beat can be taken |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_we | input | 1 | Request writes |
| req_re | input | 1 | Request reads |
| resp_valid | output | 1 | Response beat offered |
| resp_ready | input | 1 | Consumer takes the response |
| resp_rdata | output | DATA_W | Read data of the response |
| ram_addr | output | ADDR_W | RAM address pin |
| ram_wdata | output | DATA_W | RAM write data pin |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | DATA_W | RAM read data, valid LATENCY cycles after a read strobe |

## Verification
The bench builds the bridge with LATENCY=2 and RESP_DEPTH=3, not with the defaults. A two-cycle latency means two reads are in flight at once, so the admission count really has to add the in-flight reads to the stored words. The smallest legal depth makes the stall threshold land exactly on the third read, and it makes full-rate streaming depend on the credit given back by a response leaving in the same cycle.

// File: rtl/ram_bridge_pkg.sv
package ram_bridge_pkg;
  // bits needed to count from 0 up to max_val inclusive
  function automatic int unsigned count_bits(input int unsigned max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ram_bridge_rd_track.sv
module ram_bridge_rd_track #(
  parameter int unsigned LATENCY = 1,
  parameter int unsigned CNT_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  output logic             land,
  output logic [CNT_W-1:0] inflight
);
  logic [LATENCY-1:0] flags;

  generate
    if (LATENCY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= issue;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= {flags[LATENCY-2:0], issue};
      end
    end
  endgenerate

  // the oldest flag marks the cycle in which the RAM drives valid data
  assign land = flags[LATENCY-1];

  always_comb begin
    inflight = '0;
    for (int i = 0; i < LATENCY; i++) inflight = inflight + CNT_W'(flags[i]);
  end
endmodule

// File: rtl/ram_bridge_resp_fifo.sv
module ram_bridge_resp_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  used
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   used <= used + CNT_W'(1);
        2'b01:   used <= used - CNT_W'(1);
        default: used <= used;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  assign out_valid = (used != '0);
  assign out_data  = slots[rd_ptr];
endmodule

// File: rtl/ram_chan_bridge.sv
module ram_chan_bridge
  import ram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LATENCY    = 1,
  parameter int unsigned RESP_DEPTH = LATENCY + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_we,
  input  logic              req_re,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int unsigned FCNT_W = count_bits(RESP_DEPTH);
  localparam int unsigned ICNT_W = count_bits(LATENCY);
  localparam int unsigned SUM_W  = count_bits(RESP_DEPTH + LATENCY) + 1;

  logic              fire, pop, land, room;
  logic [FCNT_W-1:0] stored;
  logic [ICNT_W-1:0] inflight;
  logic [SUM_W-1:0]  committed;

  // credits: words held plus words still coming, less one leaving now
  assign pop       = resp_valid && resp_ready;
  assign committed = SUM_W'(stored) + SUM_W'(inflight) - SUM_W'(pop);
  assign room      = committed < SUM_W'(RESP_DEPTH);

  assign req_ready = !req_re || room;
  assign fire      = req_valid && req_ready;

  assign ram_addr  = req_addr;
  assign ram_wdata = req_wdata;
  assign ram_we    = fire && req_we;
  assign ram_re    = fire && req_re;

  ram_bridge_rd_track #(
    .LATENCY (LATENCY),
    .CNT_W   (ICNT_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (ram_re),
    .land     (land),
    .inflight (inflight)
  );

  ram_bridge_resp_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (RESP_DEPTH),
    .CNT_W  (FCNT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (land),
    .push_data (ram_rdata),
    .pop       (pop),
    .out_valid (resp_valid),
    .out_data  (resp_rdata),
    .used      (stored)
  );
endmodule

// File: rtl/ram_chan_bridge_chk.sv
module ram_chan_bridge_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_re,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              ram_we,
  input logic              ram_re
);
  // reads sent to the RAM minus responses taken by the consumer
  logic [15:0] owed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else owed <= owed + 16'(ram_re) - 16'(resp_valid && resp_ready);
  end

  AST_WRITE_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_re) |-> req_ready); // R1
  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> (!ram_we && !ram_re)); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (owed != 16'd0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= 16'(DEPTH)); // R5
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata))); // R8
endmodule

bind ram_chan_bridge ram_chan_bridge_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (RESP_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_re     (req_re),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_rdata (resp_rdata),
  .ram_we     (ram_we),
  .ram_re     (ram_re)
);

// File: tb/ram_chan_bridge_test.sv
`timescale 1ns/100ps
module ram_chan_bridge_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LAT = 2;
  localparam int DEPTH = 3;
  localparam int NV = 10;

  // vector fields: {we, re, addr[3:0], wdata[7:0]}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0, 8'hA0}, {1'b1, 1'b0, 4'd1, 8'hB1},
    {1'b1, 1'b0, 4'd2, 8'hC2}, {1'b1, 1'b0, 4'd3, 8'hD3},
    {1'b0, 1'b1, 4'd2, 8'h00}, {1'b0, 1'b1, 4'd0, 8'h00},
    {1'b1, 1'b0, 4'd1, 8'h5E}, {1'b0, 1'b1, 4'd1, 8'h00},
    {1'b1, 1'b1, 4'd3, 8'h77}, {1'b0, 1'b1, 4'd3, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_re = 0, resp_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, ram_we, ram_re;
  logic [DW-1:0] resp_rdata, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;

  always #2.5 clk = ~clk;

  ram_chan_bridge #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT), .RESP_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we), .req_re(req_re),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata));

  // behavioural RAM: read sees the old word, data appears LAT cycles later
  logic [DW-1:0] ram_mem [16];
  logic [DW-1:0] ram_pipe [LAT];
  always @(posedge clk) begin
    if (ram_re) ram_pipe[0] <= ram_mem[ram_addr];
    for (int i = 1; i < LAT; i++) ram_pipe[i] <= ram_pipe[i-1];
    if (ram_we) ram_mem[ram_addr] <= ram_wdata;
  end
  assign ram_rdata = ram_pipe[LAT-1];

  int n_chk = 0, n_fail = 0, n_resp = 0, n_stall = 0;
  string resp_tag = "R6";
  logic [DW-1:0] shadow [16];
  logic [DW-1:0] exp_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model and response checker, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (resp_valid && resp_ready) begin
        n_resp++;
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected response", 32'(resp_rdata), 32'hFFFF_FFFF);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(resp_rdata == e, resp_tag, 32'(resp_rdata), 32'(e));
        end
      end
      if (req_valid && !req_ready) n_stall++;
      if (req_valid && req_ready) begin
        if (req_re) exp_q.push_back(shadow[req_addr]);
        if (req_we) shadow[req_addr] = req_wdata;
      end
    end
  end

  task automatic send(input logic we, input logic re, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_we = we; req_re = re; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; req_we = 0; req_re = 0;
  endtask

  task automatic drain();
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int k, acc;
    logic [DW-1:0] held;
    // R9: reset state, with a read beat offered but not valid
    req_re = 1;
    repeat (3) @(posedge clk);
    #1;
    check(resp_valid == 1'b0, "R9 resp_valid in reset", 32'(resp_valid), 0);
    check(req_ready == 1'b1, "R9 req_ready in reset", 32'(req_ready), 1);
    check(!ram_we && !ram_re, "R9 RAM strobes in reset", {ram_we, ram_re}, 0);
    rst_n = 1;
    @(negedge clk);
    check(resp_valid == 1'b0 && req_ready == 1'b1, "R9 after reset", {resp_valid, req_ready}, 32'b01);
    req_re = 0;
    @(posedge clk); #1;

    // table walk, consumer always ready (R4 R6 R7)
    resp_ready = 1;
    resp_tag = "R6/R7";
    for (int v = 0; v < NV; v++) send(VEC[v][13], VEC[v][12], VEC[v][11:8], VEC[v][7:0]);
    drain();
    check(n_resp == 5, "R4 response count", n_resp, 5);
    check(exp_q.size() == 0, "R6 responses outstanding", exp_q.size(), 0);

    // R2: pin mapping for a write and for a read
    req_valid = 1; req_we = 1; req_re = 0; req_addr = 4'd9; req_wdata = 8'h3C;
    @(negedge clk);
    check(ram_we && !ram_re && ram_addr == 4'd9 && ram_wdata == 8'h3C, "R2 write pins",
          {ram_we, ram_re, ram_addr, ram_wdata}, {1'b1, 1'b0, 4'd9, 8'h3C});
    @(posedge clk); #1;
    req_we = 0; req_re = 1; req_addr = 4'd2;
    @(negedge clk);
    check(!ram_we && ram_re && ram_addr == 4'd2, "R2 read pins", {ram_we, ram_re, ram_addr}, {1'b0, 1'b1, 4'd2});
    @(posedge clk); #1;
    req_valid = 0; req_re = 0;
    @(negedge clk);
    check(!ram_we && !ram_re, "R2 idle pins", {ram_we, ram_re}, 0);
    drain();

    // R3: latency from the accepting cycle to resp_valid
    resp_tag = "R3";
    req_valid = 1; req_re = 1; req_addr = 4'd9;
    @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0; req_re = 0;
    k = 0;
    do begin @(negedge clk); k++; end while (!resp_valid && k < 10);
    check(k == LAT + 1, "R3 read-to-response cycles", k, LAT + 1);
    drain();

    // R5: consumer stalled, count admitted reads
    resp_ready = 0;
    resp_tag = "R6";
    acc = 0;
    req_valid = 1; req_re = 1; req_addr = 4'd0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (req_ready) acc++;
      @(posedge clk); #1;
      req_addr = (c % 2 == 0) ? 4'd2 : 4'd0;
    end
    check(acc == DEPTH, "R5 reads admitted while stalled", acc, DEPTH);
    @(negedge clk);
    check(req_ready == 1'b0, "R5 read blocked", req_ready, 0);
    // R1: a write beat is still taken while reads are blocked
    req_re = 0; req_we = 1; req_addr = 4'd7; req_wdata = 8'h99;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 write accepted while full", req_ready, 1);
    @(posedge clk); #1;
    req_valid = 0; req_we = 0;
    // R8: head response holds while stalled
    @(negedge clk);
    held = resp_rdata;
    check(resp_valid && held == 8'hA0, "R8 head response", {resp_valid, held}, {1'b1, 8'hA0});
    repeat (3) @(negedge clk);
    check(resp_valid && resp_rdata == held, "R8 held response", {resp_valid, resp_rdata}, {1'b1, held});
    @(posedge clk); #1;
    resp_ready = 1;
    drain();
    check(exp_q.size() == 0, "R6 stalled reads drained in order", exp_q.size(), 0);

    // R10: full-rate streaming
    n_stall = 0;
    for (int s = 0; s < 8; s++) send(1'b0, 1'b1, 4'(s % 4), 8'h00);
    drain();
    check(n_stall == 0, "R10 stall cycles while streaming", n_stall, 0);
    check(exp_q.size() == 0, "R6 stream responses all seen", exp_q.size(), 0);

    finish_run();
  end
endmodule